// File: doc/BRIEF.md
# Vector-Length CSR Read Rewriter

This decode-stage unit sits between instruction fetch and the issue logic that tracks register dependencies. It keeps a 5-bit pointer that names the scalar integer register currently holding the vector length. When an incoming 32-bit instruction only reads the vector-length CSR and the pointer is active, the unit swaps that instruction for a plain register-to-register move from the named scalar register. Issue logic then sees an ordinary scalar read. It needs no CSR dependency tracking and no stall.

A pointer value of zero means the length is not redirected, and every instruction passes through untouched. Software-visible decoding recognises a pure CSR read as CSRRS with rs1 = x0. A rewrite keeps the original destination. If that destination is x0, the move is still emitted but is marked as having no destination, so that no write dependency is created.

The unit has a valid/ready instruction input, a valid/ready output with one register stage, and a set/clear port for the pointer.

Top module: `csr_rd_rewrite`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1 and the pointer is zero, so a vector-length CSR read passes through unchanged.
- R2: With a non-zero pointer p, an instruction with opcode bits[6:0]=1110011, funct3 bits[14:12]=010, rs1 bits[19:15]=0 and CSR number bits[31:20]=VL_CSR (default 0xC20) is emitted as ADDI rd,p,0: imm bits[31:20]=0, rs1=p, funct3=000, the original rd in bits[11:7], opcode 0010011. out_rewritten_o is 1.
- R3: While the pointer is zero, a matching CSR read passes bit-for-bit with out_rewritten_o=0.
- R4: A CSR read whose CSR number differs from VL_CSR passes unchanged.
- R5: CSRRS with rs1 not x0, CSRRW (funct3 001), CSRRC (funct3 011) and non-CSR instructions pass unchanged with out_rewritten_o=0.
- R6: out_no_dest_o is 1 exactly when a rewritten instruction has rd = x0. It is 0 otherwise.
- R7: A pointer set on the same cycle that a matching instruction is accepted takes effect for that instruction.
- R8: When ptr_set_i and ptr_clr_i are both asserted, the clear wins and the pointer becomes zero.
- R9: An instruction accepted at a clock edge appears on the output right after that edge (one register stage).
- R10: While out_valid_o=1 and out_ready_i=0, the output word and both flags stay stable and in_ready_o is 0. A pointer change during the stall does not alter the held decision.
- R11: The pointer keeps its value across instructions until it is set or cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input instruction valid |
| in_insn_i | input | 32 | Input instruction word |
| in_ready_o | output | 1 | Unit can accept an instruction |
| ptr_set_i | input | 1 | Load pointer from ptr_idx_i |
| ptr_idx_i | input | 5 | Scalar register index holding the length |
| ptr_clr_i | input | 1 | Clear pointer (wins over set) |
| out_valid_o | output | 1 | Output instruction valid |
| out_insn_o | output | 32 | Output instruction word |
| out_rewritten_o | output | 1 | Output was substituted by a move |
| out_no_dest_o | output | 1 | Rewritten move targets x0 |
| out_ready_i | input | 1 | Downstream accepts output |

## Verification
The hardest situation to reach is a pointer change that lands while the output is stalled. In that case the held decision must survive while the next instruction, already waiting, is decided against the new pointer. The bench stalls the output with a rewritten instruction held, pulses a clear during the stall, and then releases. It checks that the held word keeps its rewrite and that the following instruction passes unchanged. Same-cycle set/clear collisions and a same-cycle set with a matching read are driven directly from the vector table.

// File: rtl/csr_rw_pkg.sv
package csr_rw_pkg;
  localparam int unsigned ILEN  = 32;
  localparam int unsigned IDX_W = 5;

  localparam logic [6:0] OP_SYSTEM = 7'b1110011;
  localparam logic [6:0] OP_IMM    = 7'b0010011;
  localparam logic [2:0] F3_CSRRS  = 3'b010;
  localparam logic [2:0] F3_ADDI   = 3'b000;

  typedef struct packed {
    logic [ILEN-1:0] insn;
    logic            rewritten;
    logic            no_dest;
  } dec_out_t;
endpackage

// File: rtl/vl_ptr_cache.sv
module vl_ptr_cache #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             clr_i,
  output logic [IDX_W-1:0] eff_o,
  output logic [IDX_W-1:0] q_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;

  // clear beats set; the updated value is visible in the same cycle
  always_comb begin
    ptr_d = ptr_q;
    if (clr_i)      ptr_d = '0;
    else if (set_i) ptr_d = idx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign eff_o = ptr_d;
  assign q_o   = ptr_q;

  assert_clr_prio_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ptr_q == '0));

  assert_set_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> (ptr_q == $past(idx_i)));

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(ptr_q));
endmodule

// File: rtl/csr_rd_match.sv
module csr_rd_match
  import csr_rw_pkg::*;
#(
  parameter logic [11:0] VL_CSR = 12'hC20
) (
  input  logic [ILEN-1:0]  insn_i,
  input  logic [IDX_W-1:0] ptr_i,
  output dec_out_t         dec_o
);
  logic [6:0]       opc;
  logic [2:0]       f3;
  logic [IDX_W-1:0] rd, rs1;
  logic [11:0]      csr;
  logic             is_pure_rd;
  logic             hit;

  assign opc = insn_i[6:0];
  assign rd  = insn_i[11:7];
  assign f3  = insn_i[14:12];
  assign rs1 = insn_i[19:15];
  assign csr = insn_i[31:20];

  assign is_pure_rd = (opc == OP_SYSTEM) && (f3 == F3_CSRRS) && (rs1 == '0);
  assign hit        = is_pure_rd && (csr == VL_CSR) && (ptr_i != '0);

  always_comb begin
    dec_o.insn      = insn_i;
    dec_o.rewritten = 1'b0;
    dec_o.no_dest   = 1'b0;
    if (hit) begin
      dec_o.insn      = {12'h000, ptr_i, F3_ADDI, rd, OP_IMM};
      dec_o.rewritten = 1'b1;
      dec_o.no_dest   = (rd == '0);
    end
  end
endmodule

// File: rtl/dec_out_reg.sv
module dec_out_reg #(
  parameter int unsigned W = 34
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         ready_o,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  input  logic         ready_i
);
  logic         valid_q;
  logic [W-1:0] data_q;

  assign ready_o = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (ready_o) begin
      valid_q <= valid_i;
      if (valid_i) data_q <= data_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (valid_o && data_o == $past(data_i)));
endmodule

// File: rtl/csr_rd_rewrite.sv
module csr_rd_rewrite
  import csr_rw_pkg::*;
#(
  parameter logic [11:0] VL_CSR = 12'hC20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [ILEN-1:0]  in_insn_i,
  output logic             in_ready_o,
  input  logic             ptr_set_i,
  input  logic [IDX_W-1:0] ptr_idx_i,
  input  logic             ptr_clr_i,
  output logic             out_valid_o,
  output logic [ILEN-1:0]  out_insn_o,
  output logic             out_rewritten_o,
  output logic             out_no_dest_o,
  input  logic             out_ready_i
);
  localparam int unsigned DW = $bits(dec_out_t);

  logic [IDX_W-1:0] ptr_eff, ptr_q;
  dec_out_t         dec_d, dec_q;
  logic [DW-1:0]    dec_q_raw;

  vl_ptr_cache #(.IDX_W(IDX_W)) u_cache (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ptr_set_i),
    .idx_i (ptr_idx_i),
    .clr_i (ptr_clr_i),
    .eff_o (ptr_eff),
    .q_o   (ptr_q)
  );

  csr_rd_match #(.VL_CSR(VL_CSR)) u_match (
    .insn_i(in_insn_i),
    .ptr_i (ptr_eff),
    .dec_o (dec_d)
  );

  dec_out_reg #(.W(DW)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(in_valid_i),
    .data_i (dec_d),
    .ready_o(in_ready_o),
    .valid_o(out_valid_o),
    .data_o (dec_q_raw),
    .ready_i(out_ready_i)
  );

  assign dec_q           = dec_out_t'(dec_q_raw);
  assign out_insn_o      = dec_q.insn;
  assign out_rewritten_o = dec_q.rewritten;
  assign out_no_dest_o   = dec_q.no_dest;

  assert_move_fmt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_rewritten_o) |->
      (out_insn_o[6:0] == OP_IMM && out_insn_o[14:12] == F3_ADDI &&
       out_insn_o[31:20] == 12'h000 && out_insn_o[19:15] != '0));

  assert_no_dest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_no_dest_o) |-> (out_rewritten_o && out_insn_o[11:7] == '0));

  assert_idle_ptr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && ptr_q == '0 && !ptr_set_i) |=> !out_rewritten_o);

  assert_stall_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);
endmodule

// File: tb/csr_rd_rewrite_bench.sv
module csr_rd_rewrite_bench;
  localparam logic [11:0] VLC = 12'hC20;

  function automatic logic [31:0] f_csr(input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [4:0] rs1, input logic [11:0] csr);
    return {csr, rs1, f3, rd, 7'b1110011};
  endfunction

  function automatic logic [31:0] f_addi(input logic [4:0] rd, input logic [4:0] rs,
                                         input logic [11:0] imm);
    return {imm, rs, 3'b000, rd, 7'b0010011};
  endfunction

  typedef struct packed {
    logic        set;
    logic [4:0]  idx;
    logic        clr;
    logic [31:0] insn;
    logic [31:0] exp;
    logic        rw;
    logic        nd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R3: pointer zero after reset, read passes
    '{1'b0, 5'd0,  1'b0, f_csr(3'b010,5'd5,5'd0,VLC),  f_csr(3'b010,5'd5,5'd0,VLC),  1'b0, 1'b0, 4'd3},
    // R7: same-cycle set applies
    '{1'b1, 5'd7,  1'b0, f_csr(3'b010,5'd5,5'd0,VLC),  f_addi(5'd5,5'd7,12'h0),      1'b1, 1'b0, 4'd7},
    // R11/R2: pointer persists
    '{1'b0, 5'd0,  1'b0, f_csr(3'b010,5'd9,5'd0,VLC),  f_addi(5'd9,5'd7,12'h0),      1'b1, 1'b0, 4'd11},
    // R6: rd = x0
    '{1'b0, 5'd0,  1'b0, f_csr(3'b010,5'd0,5'd0,VLC),  f_addi(5'd0,5'd7,12'h0),      1'b1, 1'b1, 4'd6},
    // R4: other CSR
    '{1'b0, 5'd0,  1'b0, f_csr(3'b010,5'd5,5'd0,12'hC21), f_csr(3'b010,5'd5,5'd0,12'hC21), 1'b0, 1'b0, 4'd4},
    // R5: CSRRS with rs1 != x0
    '{1'b0, 5'd0,  1'b0, f_csr(3'b010,5'd5,5'd3,VLC),  f_csr(3'b010,5'd5,5'd3,VLC),  1'b0, 1'b0, 4'd5},
    // R5: CSRRW
    '{1'b0, 5'd0,  1'b0, f_csr(3'b001,5'd5,5'd0,VLC),  f_csr(3'b001,5'd5,5'd0,VLC),  1'b0, 1'b0, 4'd5},
    // R5: CSRRC
    '{1'b0, 5'd0,  1'b0, f_csr(3'b011,5'd5,5'd0,VLC),  f_csr(3'b011,5'd5,5'd0,VLC),  1'b0, 1'b0, 4'd5},
    // R5: ordinary ADDI
    '{1'b0, 5'd0,  1'b0, f_addi(5'd1,5'd2,12'h005),    f_addi(5'd1,5'd2,12'h005),    1'b0, 1'b0, 4'd5},
    // R8: set and clear together, clear wins
    '{1'b1, 5'd12, 1'b1, f_csr(3'b010,5'd5,5'd0,VLC),  f_csr(3'b010,5'd5,5'd0,VLC),  1'b0, 1'b0, 4'd8},
    // R2: top register index
    '{1'b1, 5'd31, 1'b0, f_csr(3'b010,5'd31,5'd0,VLC), f_addi(5'd31,5'd31,12'h0),    1'b1, 1'b0, 4'd2},
    // R8: clear alone
    '{1'b0, 5'd0,  1'b1, f_csr(3'b010,5'd5,5'd0,VLC),  f_csr(3'b010,5'd5,5'd0,VLC),  1'b0, 1'b0, 4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic        in_ready;
  logic        ptr_set = 1'b0;
  logic [4:0]  ptr_idx = '0;
  logic        ptr_clr = 1'b0;
  logic        out_valid;
  logic [31:0] out_insn;
  logic        out_rw;
  logic        out_nd;
  logic        out_ready = 1'b1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csr_rd_rewrite u_csr_rd_rewrite (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_insn_i(in_insn), .in_ready_o(in_ready),
    .ptr_set_i(ptr_set), .ptr_idx_i(ptr_idx), .ptr_clr_i(ptr_clr),
    .out_valid_o(out_valid), .out_insn_o(out_insn),
    .out_rewritten_o(out_rw), .out_no_dest_o(out_nd), .out_ready_i(out_ready)
  );

  task automatic chk(input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid/in_ready", {33'b0, out_valid, in_ready}, {33'b0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {34'b0, out_valid}, 35'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_insn = VECS[i].insn;
      ptr_set = VECS[i].set; ptr_idx = VECS[i].idx; ptr_clr = VECS[i].clr;
      @(posedge clk); #1;
      // R9: visible just after the accepting edge
      chk($sformatf("R%0d vec%0d", VECS[i].req, i),
          {out_valid, out_insn, out_rw, out_nd},
          {1'b1, VECS[i].exp, VECS[i].rw, VECS[i].nd});
      @(negedge clk);
      in_valid = 1'b0; ptr_set = 1'b0; ptr_clr = 1'b0;
      @(posedge clk); #1;
      chk("R9 bubble", {34'b0, out_valid}, 35'b0);
    end

    // R10: backpressure with pointer cleared during the stall
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_insn = f_csr(3'b010, 5'd3, 5'd0, VLC);
    ptr_set = 1'b1; ptr_idx = 5'd4;
    @(posedge clk); #1;
    chk("R10 first held", {out_valid, out_insn, out_rw, out_nd},
        {1'b1, f_addi(5'd3, 5'd4, 12'h0), 1'b1, 1'b0});
    @(negedge clk);
    ptr_set = 1'b0;
    in_insn = f_csr(3'b010, 5'd6, 5'd0, VLC);
    ptr_clr = 1'b1;
    chk("R10 in_ready low", {34'b0, in_ready}, 35'b0);
    @(negedge clk);
    ptr_clr = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R10 stable", {out_valid, out_insn, out_rw, out_nd},
          {1'b1, f_addi(5'd3, 5'd4, 12'h0), 1'b1, 1'b0});
    end
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk); #1;
    chk("R10 next after release", {out_valid, out_insn, out_rw, out_nd},
        {1'b1, f_csr(3'b010, 5'd6, 5'd0, VLC), 1'b0, 1'b0});
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R9 drained", {34'b0, out_valid}, 35'b0);

    // R1: asynchronous reset clears the pointer
    @(negedge clk);
    ptr_set = 1'b1; ptr_idx = 5'd9;
    @(negedge clk);
    ptr_set = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", {34'b0, out_valid}, 35'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_insn = f_csr(3'b010, 5'd5, 5'd0, VLC);
    @(posedge clk); #1;
    chk("R1 pointer zero after reset", {out_valid, out_insn, out_rw, out_nd},
        {1'b1, f_csr(3'b010, 5'd5, 5'd0, VLC), 1'b0, 1'b0});
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule